// File: doc/BRIEF.md
# Two-Wire Monochrome PAL Video Timing Generator

This block produces non-interlaced PAL composite timing on two binary outputs. An external resistor network sums them into three video levels. With `sync_o` low the line sits at the sync tip. With `sync_o` high it sits at black, or at white when `luma_o` is also high. The block counts clocks along each line and lines down each field. It emits the horizontal sync pulse, the vertical interval built from short and broad half-line pulses, and blanking around the picture.

Inside the active window the block asks a pixel source for one byte at the start of each 8-pixel group. It presents the active line number and the group index on the same cycle and samples `byte_i` combinationally. It then shifts the bits out on `luma_o`, most significant first. A column-mode input selects 64-column mode, where a pixel lasts `PIX_DIV` clocks, or 32-column mode, where it lasts twice that. Either mode fills the same window, so the sync timing never depends on the mode.

Top module: `pal_two_wire_video`

## Requirements
- R1: While `rst_ni` is low, `sync_o` is 1, `luma_o` is 0 and `byte_req_o` is 0.
- R2: Both outputs are registered. They show, one clock later, the state for the position the counters held at that edge. Position runs x = 0..LINE_CLKS-1 and line y = 0..LINES-1, and both start at 0 after reset. On lines y >= 8, `sync_o` is low for x < HSYNC_CLKS and high otherwise.
- R3: Lines 0..7 are split into 16 half-lines h = 2y + (x >= LINE_CLKS/2). Half-lines 0..4 and 10..14 carry a short pulse: `sync_o` is low for the first SHORT_CLKS of the half-line. Half-lines 5..9 carry a broad pulse, low for the first BROAD_CLKS. Half-line 15 stays high.
- R4: A field is exactly LINES lines. After line LINES-1 the vertical interval restarts at line 0.
- R5: `luma_o` is never 1 while `sync_o` is 0.
- R6: `luma_o` is 0 outside the window made of lines ACT_START..ACT_START+ACT_LINES-1 and positions x = H_START..H_START+PIX64*PIX_DIV-1.
- R7: In 64-column mode (mode bit 1) pixel n covers window positions n*PIX_DIV..(n+1)*PIX_DIV-1, for n = 0..PIX64-1.
- R8: In 32-column mode (mode bit 0) each pixel lasts 2*PIX_DIV clocks. The line then holds PIX64/2 pixels in the same window.
- R9: `byte_req_o` is high on the first clock of each 8-pixel group. On that clock `byte_idx_o` is the pixel index divided by 8 and `line_o` is y-ACT_START. Bit 7 of the sampled `byte_i` is the group's first pixel, and later pixels follow down to bit 0.
- R10: `mode_i` is taken in at the edge where x = LINE_CLKS-1 and rules the whole next line. A change in mid-line has no effect until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Column mode: 1 = 64 columns, 0 = 32 columns |
| byte_i | input | 8 | Pixel byte for the requested group, MSB first |
| sync_o | output | 1 | Sync wire; low = sync tip |
| luma_o | output | 1 | Luminance wire; high = white |
| byte_req_o | output | 1 | Start of an 8-pixel group |
| byte_idx_o | output | $clog2(PIX64/8) | Group index within the line |
| line_o | output | $clog2(ACT_LINES) | Active line number |

## Verification
The bench builds the block with a 64-clock line and a 20-line field. It uses 3- and 27-clock sync pulses and a 16-pixel window with PIX_DIV = 1, starting at x = 12 on lines 9 to 14. A full field then takes 1280 clocks, so several complete fields fit in one run. Every vertical-interval half-line, every field wrap and every window edge is compared cycle by cycle. Both column modes run for whole fields. A final phase toggles the mode at arbitrary clocks, so mode changes fall in mid-line and right at line ends.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic {MODE_32 = 1'b0, MODE_64 = 1'b1} col_mode_e;
  localparam int VS_LINES = 8;
  localparam int VS_SHORT_A_END = 5;
  localparam int VS_BROAD_END = 10;
  localparam int VS_SHORT_B_END = 15;
endpackage

// File: rtl/pal_line_timer.sv
module pal_line_timer #(
  parameter int LINE_CLKS = 1024,
  parameter int LINES = 312,
  localparam int X_W = $clog2(LINE_CLKS),
  localparam int Y_W = $clog2(LINES)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  output logic [X_W-1:0] x_o,
  output logic [Y_W-1:0] y_o,
  output logic           eol_o
);
  localparam logic [X_W-1:0] X_LAST = X_W'(LINE_CLKS - 1);
  localparam logic [Y_W-1:0] Y_LAST = Y_W'(LINES - 1);

  assign eol_o = (x_o == X_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o <= '0;
      y_o <= '0;
    end else if (eol_o) begin
      x_o <= '0;
      y_o <= (y_o == Y_LAST) ? '0 : y_o + 1'b1;
    end else begin
      x_o <= x_o + 1'b1;
    end
  end

  assert_line_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |=> (x_o == '0));
  assert_field_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eol_o && y_o == Y_LAST) |=> (y_o == '0));
endmodule

// File: rtl/pal_sync_gen.sv
module pal_sync_gen
  import pal_pkg::*;
#(
  parameter int LINE_CLKS = 1024,
  parameter int LINES = 312,
  parameter int HSYNC_CLKS = 75,
  parameter int SHORT_CLKS = 38,
  parameter int BROAD_CLKS = 437,
  localparam int X_W = $clog2(LINE_CLKS),
  localparam int Y_W = $clog2(LINES)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [X_W-1:0] x_i,
  input  logic [Y_W-1:0] y_i,
  output logic           sync_o
);
  localparam int HALF = LINE_CLKS / 2;

  logic second_half;
  logic [X_W-1:0] xh;
  int half_idx;
  logic sync_d;

  always_comb begin
    second_half = (int'(x_i) >= HALF);
    xh = second_half ? x_i - X_W'(HALF) : x_i;
    half_idx = int'(y_i) * 2 + (second_half ? 1 : 0);
    if (int'(y_i) >= VS_LINES)
      sync_d = (int'(x_i) >= HSYNC_CLKS);
    else if (half_idx < VS_SHORT_A_END)
      sync_d = (int'(xh) >= SHORT_CLKS);
    else if (half_idx < VS_BROAD_END)
      sync_d = (int'(xh) >= BROAD_CLKS);
    else if (half_idx < VS_SHORT_B_END)
      sync_d = (int'(xh) >= SHORT_CLKS);
    else
      sync_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_o <= 1'b1;
    else         sync_o <= sync_d;
  end

  assert_line_starts_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_i == '0) |=> !sync_o);
  assert_hsync_ends_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(x_i) == HSYNC_CLKS && int'(y_i) >= VS_LINES) |=> sync_o);
  assert_quiet_half_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(y_i) == VS_LINES - 1 && int'(x_i) >= HALF) |=> sync_o);
endmodule

// File: rtl/pal_pixel_shifter.sv
module pal_pixel_shifter
  import pal_pkg::*;
#(
  parameter int LINE_CLKS = 1024,
  parameter int LINES = 312,
  parameter int H_START = 192,
  parameter int PIX64 = 512,
  parameter int PIX_DIV = 1,
  parameter int ACT_START = 41,
  parameter int ACT_LINES = 240,
  localparam int X_W = $clog2(LINE_CLKS),
  localparam int Y_W = $clog2(LINES),
  localparam int BI_W = $clog2(PIX64 / 8),
  localparam int LN_W = $clog2(ACT_LINES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [X_W-1:0]  x_i,
  input  logic [Y_W-1:0]  y_i,
  input  logic            eol_i,
  input  logic            mode_i,
  input  logic [7:0]      byte_i,
  output logic            byte_req_o,
  output logic [BI_W-1:0] byte_idx_o,
  output logic [LN_W-1:0] line_o,
  output logic            luma_o
);
  localparam int WIN = PIX64 * PIX_DIV;
  localparam int DIV_SH = $clog2(PIX_DIV);

  col_mode_e mode_q;
  logic in_rows, in_cols, win, pix_start;
  logic [X_W-1:0] rel, pix_idx, sub_mask;
  int sh;
  logic [7:0] sh_q;

  always_comb begin
    in_rows = (int'(y_i) >= ACT_START) && (int'(y_i) < ACT_START + ACT_LINES);
    in_cols = (int'(x_i) >= H_START) && (int'(x_i) < H_START + WIN);
    win = in_rows && in_cols;
    rel = x_i - X_W'(H_START);
    sh = (mode_q == MODE_64) ? DIV_SH : DIV_SH + 1;
    pix_idx = rel >> sh;
    sub_mask = (X_W'(1) << sh) - X_W'(1);
    pix_start = win && ((rel & sub_mask) == '0);
    byte_req_o = pix_start && (pix_idx[2:0] == 3'd0);
    byte_idx_o = pix_idx[3 +: BI_W];
    line_o = in_rows ? LN_W'(int'(y_i) - ACT_START) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= MODE_32;
    else if (eol_i) mode_q <= col_mode_e'(mode_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      luma_o <= 1'b0;
      sh_q   <= '0;
    end else if (!win) begin
      luma_o <= 1'b0;
    end else if (byte_req_o) begin
      luma_o <= byte_i[7];
      sh_q   <= {byte_i[6:0], 1'b0};
    end else if (pix_start) begin
      luma_o <= sh_q[7];
      sh_q   <= {sh_q[6:0], 1'b0};
    end
  end

  assert_dark_outside_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win |=> !luma_o);
  assert_first_bit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_req_o |=> (luma_o == $past(byte_i[7])));
  assert_mode_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eol_i |=> $stable(mode_q));
endmodule

// File: rtl/pal_two_wire_video.sv
module pal_two_wire_video #(
  parameter int LINE_CLKS = 1024,
  parameter int LINES = 312,
  parameter int HSYNC_CLKS = 75,
  parameter int SHORT_CLKS = 38,
  parameter int BROAD_CLKS = 437,
  parameter int H_START = 192,
  parameter int PIX64 = 512,
  parameter int PIX_DIV = 1,
  parameter int ACT_START = 41,
  parameter int ACT_LINES = 240,
  localparam int BI_W = $clog2(PIX64 / 8),
  localparam int LN_W = $clog2(ACT_LINES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_i,
  input  logic [7:0]      byte_i,
  output logic            sync_o,
  output logic            luma_o,
  output logic            byte_req_o,
  output logic [BI_W-1:0] byte_idx_o,
  output logic [LN_W-1:0] line_o
);
  localparam int X_W = $clog2(LINE_CLKS);
  localparam int Y_W = $clog2(LINES);

  logic [X_W-1:0] x;
  logic [Y_W-1:0] y;
  logic eol;

  pal_line_timer #(.LINE_CLKS(LINE_CLKS), .LINES(LINES)) u_timer (
    .clk_i, .rst_ni, .x_o(x), .y_o(y), .eol_o(eol)
  );

  pal_sync_gen #(
    .LINE_CLKS(LINE_CLKS), .LINES(LINES), .HSYNC_CLKS(HSYNC_CLKS),
    .SHORT_CLKS(SHORT_CLKS), .BROAD_CLKS(BROAD_CLKS)
  ) u_sync (
    .clk_i, .rst_ni, .x_i(x), .y_i(y), .sync_o
  );

  pal_pixel_shifter #(
    .LINE_CLKS(LINE_CLKS), .LINES(LINES), .H_START(H_START), .PIX64(PIX64),
    .PIX_DIV(PIX_DIV), .ACT_START(ACT_START), .ACT_LINES(ACT_LINES)
  ) u_pix (
    .clk_i, .rst_ni, .x_i(x), .y_i(y), .eol_i(eol), .mode_i, .byte_i,
    .byte_req_o, .byte_idx_o, .line_o, .luma_o
  );

  assert_no_white_in_sync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_o |-> !luma_o);
endmodule

// File: tb/sim_pal_two_wire_video.sv
module sim_pal_two_wire_video;
  localparam int LC = 64, NL = 20, HS = 5, SH = 3, BR = 27;
  localparam int HST = 12, P64 = 16, PD = 1, AS = 9, AL = 6;
  localparam int WIN = P64 * PD;
  localparam int BI_W = $clog2(P64 / 8), LN_W = $clog2(AL);

  logic clk = 1'b0, rst_ni = 1'b0, mode_i = 1'b1;
  logic [7:0] byte_i;
  logic sync_o, luma_o, byte_req_o;
  logic [BI_W-1:0] byte_idx_o;
  logic [LN_W-1:0] line_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(int ln, int bi);
    return 8'((ln * 37 + bi * 91 + 'h5A) ^ (ln << 4));
  endfunction

  always_comb byte_i = pat(int'(line_o), int'(byte_idx_o));

  pal_two_wire_video #(
    .LINE_CLKS(LC), .LINES(NL), .HSYNC_CLKS(HS), .SHORT_CLKS(SH), .BROAD_CLKS(BR),
    .H_START(HST), .PIX64(P64), .PIX_DIV(PD), .ACT_START(AS), .ACT_LINES(AL)
  ) u0 (
    .clk_i(clk), .rst_ni, .mode_i, .byte_i, .sync_o, .luma_o,
    .byte_req_o, .byte_idx_o, .line_o
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_sync(int x, int y);
    int h, xh;
    if (y >= 8) return x >= HS;
    h = 2 * y + (x >= LC / 2 ? 1 : 0);
    xh = x % (LC / 2);
    if (h < 5 || (h >= 10 && h < 15)) return xh >= SH;
    if (h < 10) return xh >= BR;
    return 1'b1;
  endfunction

  function automatic bit in_win(int x, int y);
    return y >= AS && y < AS + AL && x >= HST && x < HST + WIN;
  endfunction

  function automatic int pix_of(int x, int m);
    return m ? (x - HST) / PD : (x - HST) / (2 * PD);
  endfunction

  function automatic bit exp_luma(int x, int y, int m);
    logic [7:0] b;
    int idx;
    if (!in_win(x, y)) return 1'b0;
    idx = pix_of(x, m);
    b = pat(y - AS, idx / 8);
    return b[7 - idx % 8];
  endfunction

  initial begin
    int px = 0, py = 0, lm = 0;
    repeat (3) @(negedge clk);
    check(sync_o == 1'b1, "R1", sync_o, 1);
    check(luma_o == 1'b0, "R1", luma_o, 0);
    check(byte_req_o == 1'b0, "R1", byte_req_o, 0);
    rst_ni = 1'b1;
    for (int cyc = 0; cyc < 9 * LC * NL; cyc++) begin
      bit es, el, er, w;
      int per, rel;
      string stag, ltag;
      @(negedge clk);
      es = exp_sync(px, py);
      el = exp_luma(px, py, lm);
      w = in_win(px, py);
      stag = (py == 0) ? "R4" : (py < 8) ? "R3" : "R2";
      ltag = !w ? "R6" : (lm != 0) ? "R7" : "R8";
      check(sync_o == es, stag, sync_o, es);
      check(luma_o == el, ltag, luma_o, el);
      check(!(sync_o == 1'b0 && luma_o == 1'b1), "R5", luma_o, 0);
      if (w && lm != int'(mode_i)) check(luma_o == el, "R10", luma_o, el);
      if (px == LC - 1) lm = int'(mode_i);
      px++;
      if (px == LC) begin
        px = 0;
        py = (py == NL - 1) ? 0 : py + 1;
      end
      w = in_win(px, py);
      per = lm ? PD : 2 * PD;
      rel = px - HST;
      er = w && (rel % per == 0) && (pix_of(px, lm) % 8 == 0);
      check(byte_req_o == er, "R9", byte_req_o, er);
      if (er) begin
        check(int'(byte_idx_o) == pix_of(px, lm) / 8, "R9", byte_idx_o, pix_of(px, lm) / 8);
        check(int'(line_o) == py - AS, "R9", line_o, py - AS);
      end
      if (cyc == 3 * LC * NL) mode_i = 1'b0;
      if (cyc > 6 * LC * NL && cyc % 45 == 0) mode_i = ~mode_i;
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule